// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing controller of a byte-addressed serial memory. It samples the two bus lines (serial clock and open-drain data) with the system clock, recognises start and stop conditions, and decodes the bus transactions. A transaction selects the device with an address word that carries a fixed device code and three strap bits. It then sets an internal word address, and either writes data bytes or streams bytes back to the bus master.

The memory array itself sits outside. The controller drives it through a simple synchronous port, where a read returns data one clock after the request. The surrounding logic answers a write-protect query for the address of each incoming byte. Bytes of a write sequence are collected in a page buffer. They reach the array only after the stop condition that ends the sequence, during a self-timed write period of a programmable number of clocks. While that period runs, the device does not answer its address.

Top module: `twi_mem_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) sends the controller from any state to the device-address phase with SDA released. A stop condition (SDA rising while SCL is high) returns it to idle with SDA released, and the idle state never drives SDA.
- R2: A device address word is accepted only when bits [7:4] equal 1010 and bits [3:1] equal the strap inputs. Bit 0 selects read when 1 and write when 0. On a mismatch the word is not acknowledged and nothing more is driven until the next start.
- R3: Every accepted word (device address, word address, write data) is acknowledged by pulling SDA low for the whole ninth SCL high phase. The controller changes SDA only while SCL is low.
- R4: A write of one data byte to word address A stores that byte at A once the stop condition ends the sequence, and no other location changes.
- R5: During a write, the low four address bits advance after each byte and wrap within the 16-byte page, while the upper four bits stay fixed. A partial page writes only the locations that were received.
- R6: No array write happens before the stop that ends a write sequence. From that stop, a write period of WR_CYCLES clocks runs, and during it the device address is not acknowledged and no array read is issued.
- R7: A read returns the byte at the current word address, most significant bit first, with each bit driven after an SCL falling edge. A write of a word address followed by a repeated start and a read device word gives a random read.
- R8: After each byte sent, the word address advances over the full 8 bits (FFh wraps to 00h). A master acknowledge fetches and sends the next byte. A master no-acknowledge ends the transfer, and a later read without a word address continues at the advanced address.
- R9: A write byte refused by the write-protect query for its address is still acknowledged but is not stored. Bytes that are not refused in the same sequence are stored.
- R10: The recovery sequence (a start, nine clocks with SDA released, another start, then a stop) returns the controller to idle. A partly received byte before it is discarded, and the next transaction works normally.
- R11: A stop after a write sequence that carried no data bytes starts no write period, so the device answers its address immediately after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 (open drain) |
| strap_i | input | 3 | Device select strap bits |
| mem_addr | output | ADDR_W | Array address for read or write |
| mem_rd_en | output | 1 | Array read request; data valid next clock |
| mem_rdata | input | 8 | Array read data |
| mem_wr | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| wp_addr | output | ADDR_W | Address of the byte being received, for the protect query |
| wp_deny | input | 1 | Protect query answer; 1 refuses the byte |

## Verification
The bench builds the controller with WR_CYCLES set to 300 instead of the multi-millisecond default. That puts the end of the write period inside a short run, so the bench can probe the device address both while the period is still running and after it has ended. SYNC_STAGES stays at 2 and PAGE_BYTES at 16. With these values the page wrap, the FFh-to-00h read wrap, and the split of protected and writable halves all fall on ordinary addresses.

// File: rtl/twi_pkg.sv
package twi_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADR,
      ST_WDAT,
      ST_TX,
      ST_MACK,
      ST_SKIP
   } twi_st_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   initial begin
      assert (STAGES >= 2) else $fatal(1, "twi_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_ff[STAGES-1];
         sda_p  <= sda_ff[STAGES-1];
      end
   end

   logic scl_s;
   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 16,
   parameter int WR_CYCLES  = 625000
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    put_en,
   input  logic [$clog2(PAGE_BYTES)-1:0]           put_col,
   input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]    put_page,
   input  logic [7:0]                              put_data,
   input  logic                                    clr,
   input  logic                                    go,
   output logic                                    busy,
   output logic                                    mem_wr,
   output logic [ADDR_W-1:0]                       mem_waddr,
   output logic [7:0]                              mem_wdata
);

   localparam int COL_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - COL_W;
   localparam int TMR_W  = $clog2(WR_CYCLES + 1);
   localparam logic [TMR_W-1:0] PB_T   = TMR_W'(PAGE_BYTES);
   localparam logic [TMR_W-1:0] LAST_T = TMR_W'(WR_CYCLES - 1);

   initial begin
      assert (PAGE_BYTES == (1 << COL_W)) else $fatal(1, "twi_page_store: PAGE_BYTES must be a power of two");
      assert (WR_CYCLES >= PAGE_BYTES) else $fatal(1, "twi_page_store: WR_CYCLES shorter than a page");
   end

   logic [PAGE_BYTES*8-1:0] flat;
   logic [PAGE_BYTES-1:0]   mask_q;
   logic [PAGE_W-1:0]       page_q;
   logic [TMR_W-1:0]        tmr_q;
   logic                    busy_q;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (put_en && put_col == COL_W'(g))
            byte_q <= put_data;
      end
      assign flat[g*8 +: 8] = byte_q;
   end

   logic done;
   assign done = busy_q && tmr_q == LAST_T;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         page_q <= '0;
         tmr_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         if (clr || done)
            mask_q <= '0;
         else if (put_en)
            mask_q[put_col] <= 1'b1;
         if (put_en)
            page_q <= put_page;
         if (busy_q) begin
            tmr_q <= tmr_q + 1'b1;
            if (done)
               busy_q <= 1'b0;
         end else if (go && |mask_q) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
         end
      end
   end

   logic [COL_W-1:0] idx;
   assign idx       = tmr_q[COL_W-1:0];
   assign busy      = busy_q;
   assign mem_wr    = busy_q && tmr_q < PB_T && mask_q[idx];
   assign mem_waddr = {page_q, idx};
   assign mem_wdata = flat[idx*8 +: 8];

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
   import twi_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_BYTES  = 16,
   parameter int         WR_CYCLES   = 625000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        strap_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   input  logic [7:0]        mem_rdata,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic [ADDR_W-1:0] wp_addr,
   input  logic              wp_deny
);

   localparam int COL_W = $clog2(PAGE_BYTES);

   initial begin
      assert (ADDR_W <= 8 && ADDR_W > COL_W) else $fatal(1, "twi_mem_slave: ADDR_W out of range");
   end

   logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   twi_st_e           state;
   logic [3:0]        cnt;
   logic [7:0]        sh, tx;
   logic [ADDR_W-1:0] addr;
   logic              oe_q, rw_q, fetch_q, load_q;
   logic              st_busy;
   logic [ADDR_W-1:0] st_waddr;

   logic dev_hit, byte_end, put_en, clr;
   assign byte_end = scl_fall && cnt == 4'd8;
   assign dev_hit  = sh[7:4] == DEV_CODE && sh[3:1] == strap_i && !st_busy;
   assign put_en   = !start_ev && !stop_ev && state == ST_WDAT && byte_end && !wp_deny;
   assign clr      = !start_ev && !stop_ev && state == ST_DEV && byte_end && dev_hit && !sh[0];

   twi_page_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .put_en(put_en), .put_col(addr[COL_W-1:0]), .put_page(addr[ADDR_W-1:COL_W]),
      .put_data(sh), .clr(clr), .go(stop_ev),
      .busy(st_busy), .mem_wr(mem_wr), .mem_waddr(st_waddr), .mem_wdata(mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         tx      <= '0;
         addr    <= '0;
         oe_q    <= 1'b0;
         rw_q    <= 1'b0;
         fetch_q <= 1'b0;
         load_q  <= 1'b0;
      end else begin
         fetch_q <= 1'b0;
         load_q  <= fetch_q;
         if (load_q)
            tx <= mem_rdata;
         if (start_ev) begin
            state <= ST_DEV;
            cnt   <= '0;
            oe_q  <= 1'b0;
         end else if (stop_ev) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_WADR, ST_WDAT: begin
                  if (scl_rise && cnt < 4'd9) begin
                     if (cnt < 4'd8)
                        sh <= {sh[6:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (byte_end) begin
                     oe_q <= 1'b1;
                     if (state == ST_DEV) begin
                        if (dev_hit) begin
                           rw_q    <= sh[0];
                           fetch_q <= sh[0];
                        end else begin
                           oe_q  <= 1'b0;
                           state <= ST_SKIP;
                        end
                     end else if (state == ST_WADR)
                        addr <= sh[ADDR_W-1:0];
                     else
                        addr <= {addr[ADDR_W-1:COL_W], addr[COL_W-1:0] + 1'b1};
                  end else if (scl_fall && cnt == 4'd9) begin
                     oe_q <= 1'b0;
                     cnt  <= '0;
                     if (state == ST_DEV && rw_q) begin
                        state <= ST_TX;
                        oe_q  <= ~tx[7];
                        tx    <= {tx[6:0], 1'b0};
                        cnt   <= 4'd1;
                     end else if (state == ST_DEV)
                        state <= ST_WADR;
                     else
                        state <= ST_WDAT;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt < 4'd8) begin
                        oe_q <= ~tx[7];
                        tx   <= {tx[6:0], 1'b0};
                        cnt  <= cnt + 1'b1;
                     end else begin
                        oe_q  <= 1'b0;
                        state <= ST_MACK;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     addr <= addr + 1'b1;
                     if (!sda_s)
                        fetch_q <= 1'b1;
                     else
                        state <= ST_SKIP;
                  end else if (scl_fall) begin
                     state <= ST_TX;
                     oe_q  <= ~tx[7];
                     tx    <= {tx[6:0], 1'b0};
                     cnt   <= 4'd1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = oe_q;
   assign mem_rd_en = fetch_q;
   assign mem_addr  = st_busy ? st_waddr : addr;
   assign wp_addr   = addr;

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
   import twi_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic       mem_rd_en,
   input logic       busy,
   input logic       start_ev,
   input logic       stop_ev,
   input logic       scl_fall,
   input logic [3:0] cnt,
   input twi_st_e    state
);

   // R3: the data line moves only while the clock line is low
   a_r3_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R1: start leads to the address phase with the line released
   a_r1_start_dev: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (state == ST_DEV && !sda_oe));

   // R1: stop leads to idle with the line released
   a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (state == ST_IDLE && !sda_oe));

   // R6: no array read while the write period runs
   a_r6_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !busy);

   // R6: the write period only begins right after a stop
   a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_ev));

   // R6: device address refused during the write period
   a_r6_nack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state == ST_DEV && scl_fall && cnt == 4'd8 && !start_ev && !stop_ev) |=> !sda_oe);

endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .mem_rd_en(mem_rd_en), .busy(st_busy), .start_ev(start_ev),
   .stop_ev(stop_ev), .scl_fall(scl_fall), .cnt(cnt), .state(state)
);

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;

   localparam int  WR_CYC = 300;
   localparam int  H      = 8;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DW = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DR = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       scl_m = 1'b1, sda_m = 1'b1, prot = 1'b0;
   logic       sda_oe, mem_rd_en, mem_wr, wp_deny;
   logic [7:0] mem_addr, mem_rdata, mem_wdata, wp_addr;
   wire        sda_line = sda_m & ~sda_oe;

   twi_mem_slave #(.WR_CYCLES(WR_CYC)) i_twi_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap_i(STRAP), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .wp_addr(wp_addr), .wp_deny(wp_deny)
   );

   // Array behind the controller, and an independent expected image
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   int         wr_pulses = 0;
   assign wp_deny = prot && (wp_addr < 8'h80);

   always @(posedge clk) begin
      if (mem_wr) begin
         mem[mem_addr] <= mem_wdata;
         wr_pulses <= wr_pulses + 1;
      end
      if (mem_rd_en)
         mem_rdata <= mem[mem_addr];
   end

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(bit ok, string tag, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic b_start;
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic b_stop;
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic put_bit(bit b);
      sda_m = b; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H/2);
      b = sda_line; tick(H/2);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic send_byte(logic [7:0] v, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv_byte(bit mack, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!mack);
   endtask

   // Write sequence plus model update; the model stores at stop
   task automatic write_seq(logic [7:0] a, logic [7:0] d[$], string tag);
      bit ack;
      logic [7:0] p = a;
      b_start;
      send_byte(DW, ack);  chk(ack, {tag, " R3 dev ack"}, ack, 1);
      send_byte(a, ack);   chk(ack, {tag, " R3 addr ack"}, ack, 1);
      foreach (d[i]) begin
         send_byte(d[i], ack); chk(ack, {tag, " R3/R9 data ack"}, ack, 1);
         if (!(prot && p < 8'h80)) exp_mem[p] = d[i];
         p = {p[7:4], p[3:0] + 4'd1};
      end
      b_stop;
   endtask

   task automatic read_seq(logic [7:0] a, int n, string tag);
      bit ack;
      logic [7:0] v, p = a;
      b_start;
      send_byte(DW, ack); chk(ack, {tag, " R7 dev ack"}, ack, 1);
      send_byte(a, ack);  chk(ack, {tag, " R7 addr ack"}, ack, 1);
      b_start;
      send_byte(DR, ack); chk(ack, {tag, " R7 read dev ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n-1, v);
         chk(v === exp_mem[p], {tag, " R7/R8 read byte"}, v, exp_mem[p]);
         p = p + 8'd1;
      end
      b_stop;
   endtask

   initial begin
      bit ack, b;
      logic [7:0] v;
      int w0;
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 8'(i) ^ 8'hA5;
         exp_mem[i] = 8'(i) ^ 8'hA5;
      end
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk(sda_oe == 1'b0, "R1 reset releases SDA", sda_oe, 0);
      chk(mem_wr == 1'b0 && mem_rd_en == 1'b0, "R1 reset no array access", mem_wr, 0);

      // R2: strap mismatch and device code mismatch are not acknowledged
      b_start;
      send_byte({4'b1010, 3'b100, 1'b0}, ack);
      chk(!ack, "R2 wrong strap nack", ack, 0);
      b_stop;
      b_start;
      send_byte({4'b1011, STRAP, 1'b0}, ack);
      chk(!ack, "R2 wrong code nack", ack, 0);
      b_stop;

      // R4/R6: single byte, write only after stop, busy window
      w0 = wr_pulses;
      b_start;
      send_byte(DW, ack);    chk(ack, "R3 dev ack", ack, 1);
      send_byte(8'h25, ack); chk(ack, "R3 addr ack", ack, 1);
      send_byte(8'h5A, ack); chk(ack, "R3 data ack", ack, 1);
      chk(wr_pulses == w0, "R6 no write before stop", wr_pulses - w0, 0);
      exp_mem[8'h25] = 8'h5A;
      b_stop;
      b_start;
      send_byte(DW, ack);
      chk(!ack, "R6 nack during write period", ack, 0);
      b_stop;
      tick(WR_CYC + 40);
      chk(wr_pulses == w0 + 1, "R4 one array write", wr_pulses - w0, 1);
      chk(mem[8'h24] === exp_mem[8'h24] && mem[8'h26] === exp_mem[8'h26],
          "R4 neighbours untouched", mem[8'h26], exp_mem[8'h26]);
      read_seq(8'h25, 1, "R4 readback");

      // R5: page write wrapping inside page 3
      write_seq(8'h3E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5 page");
      tick(WR_CYC + 40);
      read_seq(8'h30, 3, "R5 wrap");
      read_seq(8'h3D, 3, "R5 partial");

      // R8: sequential read across FFh, then continue without address
      read_seq(8'hFE, 3, "R8 wrap");
      b_start;
      send_byte(DR, ack); chk(ack, "R8 current read ack", ack, 1);
      recv_byte(1'b0, v);
      chk(v === exp_mem[8'h01], "R8 continues at 01", v, exp_mem[8'h01]);
      b_stop;

      // R9: protected half refused, upper half stored
      prot = 1'b1;
      write_seq(8'h10, '{8'hC1, 8'hC2}, "R9 low");
      tick(WR_CYC + 40);
      write_seq(8'h90, '{8'hD1}, "R9 high");
      tick(WR_CYC + 40);
      prot = 1'b0;
      read_seq(8'h10, 2, "R9 low readback");
      read_seq(8'h90, 1, "R9 high readback");
      chk(mem[8'h10] === (8'h10 ^ 8'hA5), "R9 protected byte kept", mem[8'h10], 8'h10 ^ 8'hA5);

      // R11: address-only write starts no write period
      write_seq(8'h55, '{}, "R11 dummy");
      b_start;
      send_byte(DW, ack);
      chk(ack, "R11 answered right after stop", ack, 1);
      b_stop;

      // R10: recovery after a partial byte
      b_start;
      send_byte(DW, ack);
      send_byte(8'h40, ack);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      b_start;
      for (int i = 0; i < 9; i++) get_bit(b);
      chk(b == 1'b1, "R10 ninth clock not acknowledged", b, 1);
      b_start;
      b_stop;
      chk(sda_oe == 1'b0, "R10 idle after recovery", sda_oe, 0);
      write_seq(8'h41, '{8'h77}, "R10 after recovery");
      tick(WR_CYC + 40);
      read_seq(8'h40, 2, "R10 readback");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule